// File: doc/BRIEF.md
# Oversampling ADC Conversion Sequencer

This block is the digital control logic that sits beside an oversampling analog-to-digital modulator. A processor-side interface sets the mode bit, the oversampling rate and the number of elementary conversions, and it pulses a start command or a defaults command. A sequencer clocked by the slower sampling clock counts qualified modulator samples. When it reaches the programmed length it latches the accumulated sample word into a 16-bit result. The result, a busy flag and an interrupt pulse are returned to the processor clock domain.

Two modes are supported. In on-request mode, each start command runs exactly one conversion. In continuous mode, each finished conversion immediately starts the next. The defaults command restores the default conversion setup (oversampling rate 32, two elementary conversions) and restarts a conversion at once, abandoning any conversion already running. All commands cross the clock boundary through toggle synchronisers with acknowledgement. The result crosses through a toggle handshake, so the processor side never sees a partially updated word.

Top module: `adcseq_ctrl`

## Requirements
- R1: While rst_n is low and after it is released with no command, busy is 0, irq is 0, result is 0 and trig stays 0.
- R2: With the mode bit 0, one start_pulse runs exactly one conversion: busy rises, exactly one trig and one irq follow, and then busy returns to 0 with no further irq.
- R3: A conversion lasts OSR x NEL sampling-clock cycles in which smp_valid is 1. OSR = 8 << osr_sel (osr_sel 0..7 gives 8..1024) and NEL = 1 << nel_sel (nel_sel 0..3 gives 1..8). Cycles with smp_valid at 0 are not counted.
- R4: With the mode bit 1, conversions run back to back. The next conversion begins on the first valid sample after a trig, so consecutive trig pulses are exactly OSR x NEL valid samples apart.
- R5: At the end of each conversion, trig is high for one sampling-clock cycle, in the cycle after the final counted sample. The result becomes the smp_data value presented with that final sample. irq is high for one processor-clock cycle, and result takes the new value in that same cycle.
- R6: busy rises no more than 20 processor cycles after start_pulse (at most about one sampling cycle plus the synchroniser delays) and stays 1 until the conversion ends.
- R7: A start_pulse issued while a conversion is running is ignored: it produces no additional trig or irq.
- R8: Clearing the mode bit in continuous mode lets the conversion in progress finish with exactly one more trig. After that the block is idle with busy 0.
- R9: def_pulse restarts a conversion within a few sampling cycles, even while one is running. The abandoned conversion gives no trig. The new conversion uses OSR 32 and NEL 2 (64 valid samples), and these defaults remain in force for later conversions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_cpu | input | 1 | Processor-side clock |
| clk_smp | input | 1 | Sampling clock of the modulator |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| mode_wr | input | 1 | Write strobe for the mode bit |
| mode_cont | input | 1 | Mode bit value: 1 continuous, 0 on request |
| cfg_wr | input | 1 | Write strobe for osr_sel and nel_sel (only while idle) |
| osr_sel | input | 3 | Oversampling rate select, OSR = 8 << osr_sel |
| nel_sel | input | 2 | Elementary conversion count select, NEL = 1 << nel_sel |
| start_pulse | input | 1 | One-cycle request for a single conversion |
| def_pulse | input | 1 | One-cycle defaults-and-restart command |
| smp_data | input | 16 | Accumulated modulator sample word |
| smp_valid | input | 1 | Qualifies one modulator sample in the sampling domain |
| trig | output | 1 | One sampling-cycle pulse at the end of each conversion |
| busy | output | 1 | Conversion running, in the processor domain |
| irq | output | 1 | One processor-cycle pulse when a new result is available |
| result | output | 16 | Last conversion result, in the processor domain |

## Verification
trig is due one sampling cycle after the final counted sample, so the bench counts valid samples at sampling-clock falling edges and compares the count at each trig with OSR x NEL. busy and irq pass through synchronisers of two or three stages, so the bench checks them with bounded waits of up to 20 processor cycles rather than at a fixed edge. The result is checked on the falling processor edge in which irq is high, against the data word the bench presented with the final sample. Checks that something is ignored or abandoned count trig and irq pulses over a quiet window that is longer than any synchroniser delay.

// File: rtl/adcseq_pkg.sv
// Package: types shared by the conversion sequencer modules.
// Assumes nothing beyond SystemVerilog 2017.
package adcseq_pkg;
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/adcseq_sync.sv
// Multi-stage flop synchroniser for a level or a toggle bus.
// Assumes that a multi-bit bus is either quasi-static or changes one bit at a time.
module adcseq_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Shift the input through the chain, one flop per stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else if (i == 0) stg[i] <= din;
                else stg[i] <= stg[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/adcseq_cpu_side.sv
// Processor-domain half: holds the mode bit and the conversion setup,
// turns command pulses into request toggles gated by acknowledgements,
// and brings busy and results back with an irq pulse.
// Assumes result_s is stable whenever res_tog_s changes, which holds
// because conversions last at least 8 sampling cycles.
module adcseq_cpu_side #(
    parameter int DATA_W      = 16,
    parameter int OSR_SEL_W   = 3,
    parameter int NEL_SEL_W   = 2,
    parameter int DEF_OSR_SEL = 2,
    parameter int DEF_NEL_SEL = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_wr,
    input  logic                 mode_cont,
    input  logic                 cfg_wr,
    input  logic [OSR_SEL_W-1:0] osr_sel,
    input  logic [NEL_SEL_W-1:0] nel_sel,
    input  logic                 start_pulse,
    input  logic                 def_pulse,
    input  logic                 start_ack,
    input  logic                 def_ack,
    input  logic                 busy_s,
    input  logic                 res_tog_s,
    input  logic [DATA_W-1:0]    result_s,
    output logic                 cont_q,
    output logic [OSR_SEL_W-1:0] osr_q,
    output logic [NEL_SEL_W-1:0] nel_q,
    output logic                 start_tog,
    output logic                 def_tog,
    output logic                 busy,
    output logic                 irq,
    output logic [DATA_W-1:0]    result
);
    logic [2:0] back_sync;
    logic       res_tog_d;
    logic       res_edge;

    // Mode bit register.
    always_ff @(posedge clk) begin
        if (!rst_n) cont_q <= 1'b0;
        else if (mode_wr) cont_q <= mode_cont;
    end

    // Setup registers; the defaults command overrides a plain write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osr_q <= OSR_SEL_W'(DEF_OSR_SEL);
            nel_q <= NEL_SEL_W'(DEF_NEL_SEL);
        end else if (def_pulse) begin
            osr_q <= OSR_SEL_W'(DEF_OSR_SEL);
            nel_q <= NEL_SEL_W'(DEF_NEL_SEL);
        end else if (cfg_wr) begin
            osr_q <= osr_sel;
            nel_q <= nel_sel;
        end
    end

    // Request toggles; a new command waits until the previous one is acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_tog <= 1'b0;
            def_tog   <= 1'b0;
        end else begin
            if (start_pulse && (start_tog == start_ack)) start_tog <= ~start_tog;
            if (def_pulse && (def_tog == def_ack))       def_tog   <= ~def_tog;
        end
    end

    adcseq_sync #(.WIDTH(2), .STAGES(2)) u_back_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({busy_s, res_tog_s}),
        .dout (back_sync[2:1])
    );
    assign back_sync[0] = 1'b0;
    assign busy         = back_sync[2];
    assign res_edge     = back_sync[1] ^ res_tog_d;

    // Detect a result toggle, capture the stable word and pulse irq.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_tog_d <= 1'b0;
            irq       <= 1'b0;
            result    <= '0;
        end else begin
            res_tog_d <= back_sync[1];
            irq       <= res_edge;
            if (res_edge) result <= result_s;
        end
    end

    // R5: irq lasts a single processor cycle.
    assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R5: the visible result changes only together with irq.
    assert_result_with_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> irq);
endmodule

// File: rtl/adcseq_engine.sv
// Sampling-domain sequencer: counts qualified samples per elementary
// conversion and elementary conversions per result, latches the sample
// word at the end, pulses trig and flips the result toggle.
// Assumes the setup bus only changes while the engine is idle.
module adcseq_engine
    import adcseq_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int OSR_SEL_W   = 3,
    parameter int NEL_SEL_W   = 2,
    parameter int OSR_MIN_LOG = 3,
    parameter int DEF_OSR_SEL = 2,
    parameter int DEF_NEL_SEL = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cont_a,
    input  logic [OSR_SEL_W-1:0] osr_a,
    input  logic [NEL_SEL_W-1:0] nel_a,
    input  logic                 start_tog_a,
    input  logic                 def_tog_a,
    input  logic [DATA_W-1:0]    smp_data,
    input  logic                 smp_valid,
    output logic                 start_ack,
    output logic                 def_ack,
    output logic                 busy_s,
    output logic                 trig,
    output logic                 res_tog,
    output logic [DATA_W-1:0]    result_s
);
    localparam int OSR_CNT_W = OSR_MIN_LOG + (2 ** OSR_SEL_W) - 1;
    localparam int NEL_CNT_W = (2 ** NEL_SEL_W) - 1;
    localparam int IN_W      = 1 + OSR_SEL_W + NEL_SEL_W;

    seq_state_e             state;
    logic [IN_W-1:0]        in_sync;
    logic                   cont_s;
    logic [OSR_SEL_W-1:0]   osr_s;
    logic [NEL_SEL_W-1:0]   nel_s;
    logic [1:0]             tog_sync;
    logic                   start_d;
    logic                   def_d;
    logic                   start_evt;
    logic                   def_evt;
    logic [OSR_SEL_W-1:0]   osr_run;
    logic [NEL_SEL_W-1:0]   nel_run;
    logic [OSR_CNT_W-1:0]   osr_cnt;
    logic [NEL_CNT_W-1:0]   nel_cnt;
    logic [OSR_CNT_W-1:0]   osr_last;
    logic [NEL_CNT_W-1:0]   nel_last;

    adcseq_sync #(.WIDTH(IN_W), .STAGES(2)) u_cfg_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cont_a, osr_a, nel_a}),
        .dout (in_sync)
    );
    assign {cont_s, osr_s, nel_s} = in_sync;

    adcseq_sync #(.WIDTH(2), .STAGES(2)) u_cmd_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({start_tog_a, def_tog_a}),
        .dout (tog_sync)
    );

    // Delay the synchronised toggles for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_d <= 1'b0;
            def_d   <= 1'b0;
        end else begin
            start_d <= tog_sync[1];
            def_d   <= tog_sync[0];
        end
    end

    assign start_evt = tog_sync[1] ^ start_d;
    assign def_evt   = tog_sync[0] ^ def_d;
    assign start_ack = start_d;
    assign def_ack   = def_d;
    assign busy_s    = (state == SEQ_RUN);

    // Terminal counts from the setup latched at conversion start.
    always_comb begin
        osr_last = OSR_CNT_W'((32'd1 << (OSR_MIN_LOG + 32'(osr_run))) - 32'd1);
        nel_last = NEL_CNT_W'((32'd1 << 32'(nel_run)) - 32'd1);
    end

    // Main sequencer: start, count, finish, restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            osr_run  <= OSR_SEL_W'(DEF_OSR_SEL);
            nel_run  <= NEL_SEL_W'(DEF_NEL_SEL);
            osr_cnt  <= '0;
            nel_cnt  <= '0;
            trig     <= 1'b0;
            res_tog  <= 1'b0;
            result_s <= '0;
        end else begin
            trig <= 1'b0;
            if (def_evt) begin
                state   <= SEQ_RUN;
                osr_run <= OSR_SEL_W'(DEF_OSR_SEL);
                nel_run <= NEL_SEL_W'(DEF_NEL_SEL);
                osr_cnt <= '0;
                nel_cnt <= '0;
            end else if (state == SEQ_IDLE) begin
                if (start_evt || cont_s) begin
                    state   <= SEQ_RUN;
                    osr_run <= osr_s;
                    nel_run <= nel_s;
                    osr_cnt <= '0;
                    nel_cnt <= '0;
                end
            end else if (smp_valid) begin
                if (osr_cnt == osr_last) begin
                    osr_cnt <= '0;
                    if (nel_cnt == nel_last) begin
                        nel_cnt  <= '0;
                        result_s <= smp_data;
                        trig     <= 1'b1;
                        res_tog  <= ~res_tog;
                        if (cont_s) begin
                            osr_run <= osr_s;
                            nel_run <= nel_s;
                        end else begin
                            state <= SEQ_IDLE;
                        end
                    end else begin
                        nel_cnt <= nel_cnt + 1'b1;
                    end
                end else begin
                    osr_cnt <= osr_cnt + 1'b1;
                end
            end
        end
    end

    // R5: trig is a single sampling-cycle pulse.
    assert_trig_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig);

    // R2: a conversion only ends (busy falls) with a trig.
    assert_busy_end_trig_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_s) |-> trig);

    // R5: the sampling-side result changes only when trig fires.
    assert_result_trig_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_s) |-> trig);

    // R3: the sample counter never passes its terminal count.
    assert_osr_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        osr_cnt <= osr_last);
endmodule

// File: rtl/adcseq_ctrl.sv
// Top of the conversion sequencer: joins the processor-domain half
// and the sampling-domain engine.
// Assumes clk_smp is slower than clk_cpu and rst_n is held low for
// several cycles of both clocks.
module adcseq_ctrl #(
    parameter int DATA_W      = 16,
    parameter int OSR_SEL_W   = 3,
    parameter int NEL_SEL_W   = 2,
    parameter int OSR_MIN_LOG = 3,
    parameter int DEF_OSR_SEL = 2,
    parameter int DEF_NEL_SEL = 1
) (
    input  logic                 clk_cpu,
    input  logic                 clk_smp,
    input  logic                 rst_n,
    input  logic                 mode_wr,
    input  logic                 mode_cont,
    input  logic                 cfg_wr,
    input  logic [OSR_SEL_W-1:0] osr_sel,
    input  logic [NEL_SEL_W-1:0] nel_sel,
    input  logic                 start_pulse,
    input  logic                 def_pulse,
    input  logic [DATA_W-1:0]    smp_data,
    input  logic                 smp_valid,
    output logic                 trig,
    output logic                 busy,
    output logic                 irq,
    output logic [DATA_W-1:0]    result
);
    logic                 cont_q;
    logic [OSR_SEL_W-1:0] osr_q;
    logic [NEL_SEL_W-1:0] nel_q;
    logic                 start_tog;
    logic                 def_tog;
    logic                 start_ack;
    logic                 def_ack;
    logic [1:0]           ack_sync;
    logic                 busy_s;
    logic                 res_tog;
    logic [DATA_W-1:0]    result_s;

    adcseq_cpu_side #(
        .DATA_W(DATA_W), .OSR_SEL_W(OSR_SEL_W), .NEL_SEL_W(NEL_SEL_W),
        .DEF_OSR_SEL(DEF_OSR_SEL), .DEF_NEL_SEL(DEF_NEL_SEL)
    ) u_cpu (
        .clk        (clk_cpu),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_cont  (mode_cont),
        .cfg_wr     (cfg_wr),
        .osr_sel    (osr_sel),
        .nel_sel    (nel_sel),
        .start_pulse(start_pulse),
        .def_pulse  (def_pulse),
        .start_ack  (ack_sync[1]),
        .def_ack    (ack_sync[0]),
        .busy_s     (busy_s),
        .res_tog_s  (res_tog),
        .result_s   (result_s),
        .cont_q     (cont_q),
        .osr_q      (osr_q),
        .nel_q      (nel_q),
        .start_tog  (start_tog),
        .def_tog    (def_tog),
        .busy       (busy),
        .irq        (irq),
        .result     (result)
    );

    adcseq_sync #(.WIDTH(2), .STAGES(2)) u_ack_sync (
        .clk  (clk_cpu),
        .rst_n(rst_n),
        .din  ({start_ack, def_ack}),
        .dout (ack_sync)
    );

    adcseq_engine #(
        .DATA_W(DATA_W), .OSR_SEL_W(OSR_SEL_W), .NEL_SEL_W(NEL_SEL_W),
        .OSR_MIN_LOG(OSR_MIN_LOG),
        .DEF_OSR_SEL(DEF_OSR_SEL), .DEF_NEL_SEL(DEF_NEL_SEL)
    ) u_eng (
        .clk        (clk_smp),
        .rst_n      (rst_n),
        .cont_a     (cont_q),
        .osr_a      (osr_q),
        .nel_a      (nel_q),
        .start_tog_a(start_tog),
        .def_tog_a  (def_tog),
        .smp_data   (smp_data),
        .smp_valid  (smp_valid),
        .start_ack  (start_ack),
        .def_ack    (def_ack),
        .busy_s     (busy_s),
        .trig       (trig),
        .res_tog    (res_tog),
        .result_s   (result_s)
    );
endmodule

// File: tb/tb_adcseq_ctrl.sv
module tb_adcseq_ctrl;
    logic        clk_cpu = 1'b0;
    logic        clk_smp = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 1'b0;
    logic        mode_cont = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  osr_sel = 3'd0;
    logic [1:0]  nel_sel = 2'd0;
    logic        start_pulse = 1'b0;
    logic        def_pulse = 1'b0;
    logic [15:0] smp_data = 16'h0101;
    logic        smp_valid = 1'b1;
    logic        trig;
    logic        busy;
    logic        irq;
    logic [15:0] result;

    int checks = 0;
    int fails = 0;
    int trig_cnt = 0;
    int irq_cnt = 0;
    int valid_cnt = 0;
    int smp_cyc = 0;
    int last_trig_valid = 0;
    int last_trig_cyc = 0;
    int int_valid = 0;
    int int_cyc = 0;
    int vmode = 0;
    bit done = 1'b0;
    logic [15:0] exp_res = 16'h0;

    always #10 clk_cpu = ~clk_cpu;
    always #40 clk_smp = ~clk_smp;

    adcseq_ctrl dut (
        .clk_cpu(clk_cpu), .clk_smp(clk_smp), .rst_n(rst_n),
        .mode_wr(mode_wr), .mode_cont(mode_cont), .cfg_wr(cfg_wr),
        .osr_sel(osr_sel), .nel_sel(nel_sel), .start_pulse(start_pulse),
        .def_pulse(def_pulse), .smp_data(smp_data), .smp_valid(smp_valid),
        .trig(trig), .busy(busy), .irq(irq), .result(result)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Sampling-side monitor and stimulus on falling edges.
    always @(negedge clk_smp) begin
        smp_cyc++;
        if (rst_n && smp_valid) valid_cnt++;
        if (trig) begin
            trig_cnt++;
            int_valid = valid_cnt - last_trig_valid;
            int_cyc = smp_cyc - last_trig_cyc;
            last_trig_valid = valid_cnt;
            last_trig_cyc = smp_cyc;
            exp_res = smp_data;
        end
        smp_data <= smp_data + 16'h1357;
        smp_valid <= (vmode == 0) ? 1'b1 : ~smp_valid;
    end

    // Processor-side monitor: irq count and result at irq (R5).
    always @(negedge clk_cpu) begin
        if (rst_n && irq) begin
            irq_cnt++;
            check(result == exp_res, "R5 result at irq", int'(result), int'(exp_res));
        end
    end

    task automatic cpu_cyc(input int n);
        repeat (n) @(negedge clk_cpu);
    endtask

    task automatic write_mode(input bit c);
        @(negedge clk_cpu); mode_wr = 1'b1; mode_cont = c;
        @(negedge clk_cpu); mode_wr = 1'b0;
    endtask

    task automatic write_cfg(input int o, input int e);
        @(negedge clk_cpu); cfg_wr = 1'b1; osr_sel = 3'(o); nel_sel = 2'(e);
        @(negedge clk_cpu); cfg_wr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk_cpu); start_pulse = 1'b1;
        @(negedge clk_cpu); start_pulse = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk_cpu);
        cpu_cyc(60);
    endtask

    task automatic wait_trigs(input int n);
        int target;
        target = trig_cnt + n;
        while (trig_cnt < target) @(negedge clk_cpu);
    endtask

    // Vectors: {osr_sel[2:0], nel_sel[1:0], valid mode}
    localparam logic [5:0] VEC [6] = '{
        {3'd0, 2'd0, 1'b0}, {3'd1, 2'd2, 1'b0}, {3'd2, 2'd1, 1'b1},
        {3'd3, 2'd0, 1'b0}, {3'd0, 2'd3, 1'b1}, {3'd4, 2'd1, 1'b0}
    };

    initial begin
        int t0, i0, v0, n;
        bit seen;
        cpu_cyc(40);
        // R1: reset state
        check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
        check(irq == 1'b0, "R1 irq in reset", int'(irq), 0);
        check(result == 16'h0, "R1 result in reset", int'(result), 0);
        rst_n = 1'b1;
        cpu_cyc(200);
        check(trig_cnt == 0 && irq_cnt == 0, "R1 idle after reset", trig_cnt + irq_cnt, 0);
        check(busy == 1'b0, "R1 busy idle", int'(busy), 0);

        // Table walk: continuous intervals (R3, R4)
        for (int k = 0; k < 6; k++) begin
            int o, e, nexp;
            o = int'(VEC[k][5:3]);
            e = int'(VEC[k][2:1]);
            vmode = int'(VEC[k][0]);
            nexp = (8 << o) * (1 << e);
            write_cfg(o, e);
            cpu_cyc(20);
            write_mode(1'b1);
            wait_trigs(3);
            check(int_valid == nexp, $sformatf("R4 interval vec %0d", k), int_valid, nexp);
            check(int_cyc == nexp * (vmode + 1), $sformatf("R3 valid gating vec %0d", k),
                  int_cyc, nexp * (vmode + 1));
            write_mode(1'b0);
            wait_idle();
        end
        vmode = 0;

        // R2 and R6: single request conversion
        write_cfg(0, 0);
        cpu_cyc(20);
        t0 = trig_cnt; i0 = irq_cnt;
        pulse_start();
        seen = 1'b0;
        for (int c = 0; c < 20; c++) begin
            if (busy) seen = 1'b1;
            if (!seen) @(negedge clk_cpu);
        end
        check(seen, "R6 busy rises after start", int'(seen), 1);
        wait_idle();
        cpu_cyc(200);
        check(trig_cnt - t0 == 1, "R2 one trig per start", trig_cnt - t0, 1);
        check(irq_cnt - i0 == 1, "R2 one irq per start", irq_cnt - i0, 1);
        check(busy == 1'b0, "R2 busy low after", int'(busy), 0);

        // R7: start during a running conversion is ignored
        write_cfg(3, 0);
        cpu_cyc(20);
        t0 = trig_cnt; i0 = irq_cnt;
        pulse_start();
        while (!busy) @(negedge clk_cpu);
        cpu_cyc(30);
        pulse_start();
        wait_idle();
        cpu_cyc(300);
        check(trig_cnt - t0 == 1, "R7 start ignored while busy (trig)", trig_cnt - t0, 1);
        check(irq_cnt - i0 == 1, "R7 start ignored while busy (irq)", irq_cnt - i0, 1);

        // R8: clearing the mode bit finishes the current conversion
        write_mode(1'b1);
        wait_trigs(1);
        t0 = trig_cnt;
        write_mode(1'b0);
        wait_idle();
        cpu_cyc(1200);
        check(trig_cnt - t0 == 1, "R8 one more trig after clear", trig_cnt - t0, 1);
        check(busy == 1'b0, "R8 idle after clear", int'(busy), 0);

        // R9: defaults command abandons a long conversion
        write_cfg(7, 3);
        cpu_cyc(20);
        pulse_start();
        while (!busy) @(negedge clk_cpu);
        cpu_cyc(400);
        t0 = trig_cnt;
        @(negedge clk_cpu); def_pulse = 1'b1; v0 = valid_cnt;
        @(negedge clk_cpu); def_pulse = 1'b0;
        wait_trigs(1);
        n = last_trig_valid - v0;
        check(n >= 64 && n <= 70, "R9 restart with 64 samples", n, 64);
        wait_idle();
        cpu_cyc(200);
        check(trig_cnt - t0 == 1, "R9 abandoned conversion silent", trig_cnt - t0, 1);
        write_mode(1'b1);
        wait_trigs(3);
        check(int_valid == 64, "R9 defaults persist", int_valid, 64);
        write_mode(1'b0);
        wait_idle();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk_cpu);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule